// File: doc/BRIEF.md
# Data-Port Read Prefetch Unit

This block keeps a single 16-bit read word ready for the host side of a display processor's data port. A command load sets the address and a 4-bit command code. While that code selects a read, the unit uses free external access slots to fetch the next word into a prefetch register. It only does so in slots where the write queue is empty. Four read targets are served: a full word assembled from byte-wide video RAM, a single byte from video RAM, a word from colour RAM and a word from vertical-scroll RAM.

A host read handshakes on `host_rd_i` and `host_ready_o`. The host holds `host_rd_i` high. Ready stays low until the prefetch word is valid. In the cycle where ready is high, `host_data_o` carries the word. The following clock edge clears the valid flag and adds the auto-increment value to the address.

The narrow memories (colour and vertical-scroll RAM) and the byte read do not pad their unused bits with zeros. They take those bits from the most recently written write-queue value, which arrives on `fifo_last_i`. The internal RAMs are loaded through a simple write port.

Top module: `rd_prefetch_unit`

## Requirements
- R1: A fetch happens only on a clock edge where `slot_i` is high, `fifo_empty_i` is high, command bit 0 is 0 and the prefetch word is not yet valid. With `slot_i` low or `fifo_empty_i` low, ready never rises.
- R2: Command 4'b0000 (video RAM word read) uses two fetch slots. The first slot places the byte at the address with bit 0 forced to 0 into bits 15:8 and marks a half-fetch as pending. The second slot places the byte at the address with bit 0 forced to 1 into bits 7:0 and sets valid.
- R3: Command 4'b1100 (video RAM byte read) uses one slot. It returns the byte at the address with bit 0 inverted in bits 7:0, and `fifo_last_i[15:8]` in bits 15:8.
- R4: Command 4'b1000 (colour RAM read) uses one slot. It reads the word at index (address >> 1) modulo CRAM_DEPTH. Bits under mask 0x0EEE come from that word; every other bit comes from `fifo_last_i`.
- R5: Command 4'b0100 (vertical-scroll RAM read) uses one slot. The index is (address >> 1) & 63, and becomes 0 when it is at or above VSRAM_DEPTH. Bits under mask 0x07FF come from the RAM; bits 15:11 come from `fifo_last_i`.
- R6: When command bit 0 is 1 (write mode), a host read gets ready in the same cycle with data 0.
- R7: In read mode, `host_ready_o` stays low while `host_rd_i` is high and the prefetch word is not valid.
- R8: A completed read-mode host read clears valid and adds `autoinc_i` to the 16-bit address, which wraps. The next read returns the word at the new address.
- R9: A command load clears both the valid and the pending half-fetch flags, so no stale data or half word survives it.
- R10: Read codes outside the four listed above (bit 0 is 0) never set valid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| slot_i | input | 1 | Free external access slot this cycle |
| fifo_empty_i | input | 1 | Write queue is empty |
| fifo_last_i | input | 16 | Most recently written write-queue value |
| cmd_load_i | input | 1 | Load a new address and command code |
| cmd_code_i | input | 4 | Command code; bit 0 set means write |
| cmd_addr_i | input | 16 | Start address for the command |
| autoinc_i | input | 8 | Auto-increment added after each host read |
| host_rd_i | input | 1 | Host data-port read request, held until ready |
| host_ready_o | output | 1 | Read completes this cycle |
| host_data_o | output | 16 | Read data, valid when ready is high |
| mem_we_i | input | 1 | Internal RAM write enable |
| mem_sel_i | input | 2 | RAM select: 0 video, 1 colour, 2 vertical scroll |
| mem_addr_i | input | 16 | Byte address (video RAM) or word index (others) |
| mem_wdata_i | input | 16 | Write data; video RAM takes bits 7:0 |

## Verification
The bench counts the cycles of stall before each read is ready. A word read that finished in one slot would show a wait of 1 instead of 2. A pending flag that survived a command reload would show a wrong high byte. A fill that ignored the queue-empty condition would raise ready early, and a valid flag that survived a reload would hand back the old word with no wait. The bench also aims at the value-level corners: colour RAM index wrap, vertical-scroll indices 40 to 63 that must fold to entry 0, and the merging of `fifo_last_i` bits. A merge mistake shows up as zeros or RAM garbage in the upper bits. Unsupported read codes must stall forever, and write mode must answer at once with zero.

// File: rtl/pf_pkg.sv
package pf_pkg;
    localparam int ADDR_W = 16;

    localparam logic [3:0] CMD_VRAM_WORD = 4'b0000;
    localparam logic [3:0] CMD_VSRAM     = 4'b0100;
    localparam logic [3:0] CMD_CRAM      = 4'b1000;
    localparam logic [3:0] CMD_VRAM_BYTE = 4'b1100;

    localparam logic [15:0] CRAM_KEEP  = 16'h0EEE;
    localparam logic [15:0] VSRAM_KEEP = 16'h07FF;

    localparam logic [1:0] SEL_VRAM  = 2'd0;
    localparam logic [1:0] SEL_CRAM  = 2'd1;
    localparam logic [1:0] SEL_VSRAM = 2'd2;

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic [3:0]        code;
        logic              valid;
        logic              pending;
        logic [15:0]       data;
    } pf_state_t;
endpackage

// File: rtl/pf_byte_ram.sv
module pf_byte_ram #(
    parameter int AW = 10
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [7:0]    wdata,
    input  logic [AW-1:0] raddr,
    output logic [7:0]    rdata
);
    localparam int DEPTH = 1 << AW;

    logic [7:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
    end

    assign rdata = mem[raddr];
endmodule

// File: rtl/pf_word_ram.sv
module pf_word_ram #(
    parameter int DEPTH = 64,
    parameter int IW    = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          we,
    input  logic [IW-1:0] waddr,
    input  logic [15:0]   wdata,
    input  logic [IW-1:0] raddr,
    output logic [15:0]   rdata
);
    localparam logic [IW:0] LIMIT = (IW+1)'(DEPTH);

    logic [15:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we && ({1'b0, waddr} < LIMIT)) mem[waddr] <= wdata;
    end

    assign rdata = ({1'b0, raddr} < LIMIT) ? mem[raddr] : 16'h0000;
endmodule

// File: rtl/rd_prefetch_unit.sv
module rd_prefetch_unit
    import pf_pkg::*;
#(
    parameter int VRAM_AW     = 10,
    parameter int CRAM_DEPTH  = 64,
    parameter int VSRAM_DEPTH = 40,
    parameter int INC_W       = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              slot_i,
    input  logic              fifo_empty_i,
    input  logic [15:0]       fifo_last_i,
    input  logic              cmd_load_i,
    input  logic [3:0]        cmd_code_i,
    input  logic [ADDR_W-1:0] cmd_addr_i,
    input  logic [INC_W-1:0]  autoinc_i,
    input  logic              host_rd_i,
    output logic              host_ready_o,
    output logic [15:0]       host_data_o,
    input  logic              mem_we_i,
    input  logic [1:0]        mem_sel_i,
    input  logic [ADDR_W-1:0] mem_addr_i,
    input  logic [15:0]       mem_wdata_i
);
    localparam int CRAM_IW  = $clog2(CRAM_DEPTH);
    localparam int VS_IW    = $clog2(VSRAM_DEPTH);
    localparam logic [6:0] VS_LIM = 7'(VSRAM_DEPTH);

    pf_state_t st_q, st_d;

    // exported state for the bound checker
    logic              valid_q, pending_q;
    logic [3:0]        code_q;
    logic [ADDR_W-1:0] addr_q;
    assign valid_q   = st_q.valid;
    assign pending_q = st_q.pending;
    assign code_q    = st_q.code;
    assign addr_q    = st_q.addr;

    // memory read addressing
    logic [VRAM_AW-1:0] vram_raddr;
    logic [7:0]         vram_rdata;
    logic [CRAM_IW-1:0] cram_raddr;
    logic [15:0]        cram_rdata;
    logic [5:0]         vs_full;
    logic [VS_IW-1:0]   vs_raddr;
    logic [15:0]        vs_rdata;

    always_comb begin
        if (st_q.code == CMD_VRAM_BYTE)
            vram_raddr = {st_q.addr[VRAM_AW-1:1], ~st_q.addr[0]};
        else
            vram_raddr = {st_q.addr[VRAM_AW-1:1], st_q.pending};
        cram_raddr = st_q.addr[CRAM_IW:1];
        vs_full    = st_q.addr[6:1];
        vs_raddr   = ({1'b0, vs_full} < VS_LIM) ? vs_full[VS_IW-1:0] : '0;
    end

    pf_byte_ram #(.AW(VRAM_AW)) u_vram (
        .clk   (clk),
        .we    (mem_we_i && mem_sel_i == SEL_VRAM),
        .waddr (mem_addr_i[VRAM_AW-1:0]),
        .wdata (mem_wdata_i[7:0]),
        .raddr (vram_raddr),
        .rdata (vram_rdata)
    );

    pf_word_ram #(.DEPTH(CRAM_DEPTH)) u_cram (
        .clk   (clk),
        .we    (mem_we_i && mem_sel_i == SEL_CRAM),
        .waddr (mem_addr_i[CRAM_IW-1:0]),
        .wdata (mem_wdata_i),
        .raddr (cram_raddr),
        .rdata (cram_rdata)
    );

    pf_word_ram #(.DEPTH(VSRAM_DEPTH)) u_vsram (
        .clk   (clk),
        .we    (mem_we_i && mem_sel_i == SEL_VSRAM),
        .waddr (mem_addr_i[VS_IW-1:0]),
        .wdata (mem_wdata_i),
        .raddr (vs_raddr),
        .rdata (vs_rdata)
    );

    logic write_mode, fill_ok, consume;

    always_comb begin
        st_d       = st_q;
        write_mode = st_q.code[0];
        fill_ok    = slot_i & fifo_empty_i & ~write_mode & ~st_q.valid;
        consume    = host_rd_i & ~write_mode & st_q.valid;

        host_ready_o = host_rd_i & (write_mode | st_q.valid);
        host_data_o  = write_mode ? 16'h0000 : st_q.data;

        if (cmd_load_i) begin
            st_d.addr    = cmd_addr_i;
            st_d.code    = cmd_code_i;
            st_d.valid   = 1'b0;
            st_d.pending = 1'b0;
        end else if (consume) begin
            st_d.valid = 1'b0;
            st_d.addr  = st_q.addr + ADDR_W'(autoinc_i);
        end else if (fill_ok) begin
            unique case (st_q.code)
                CMD_VRAM_WORD: begin
                    if (st_q.pending) begin
                        st_d.data    = {st_q.data[15:8], vram_rdata};
                        st_d.pending = 1'b0;
                        st_d.valid   = 1'b1;
                    end else begin
                        st_d.data    = {vram_rdata, 8'h00};
                        st_d.pending = 1'b1;
                    end
                end
                CMD_VRAM_BYTE: begin
                    st_d.data  = {fifo_last_i[15:8], vram_rdata};
                    st_d.valid = 1'b1;
                end
                CMD_CRAM: begin
                    st_d.data  = (cram_rdata & CRAM_KEEP) | (fifo_last_i & ~CRAM_KEEP);
                    st_d.valid = 1'b1;
                end
                CMD_VSRAM: begin
                    st_d.data  = (vs_rdata & VSRAM_KEEP) | (fifo_last_i & ~VSRAM_KEEP);
                    st_d.valid = 1'b1;
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/pf_checker.sv
module pf_checker (
    input logic        clk,
    input logic        rst_n,
    input logic        slot_i,
    input logic        fifo_empty_i,
    input logic        cmd_load_i,
    input logic [7:0]  autoinc_i,
    input logic        host_rd_i,
    input logic        host_ready_o,
    input logic [15:0] host_data_o,
    input logic        valid,
    input logic        pending,
    input logic [3:0]  code,
    input logic [15:0] addr
);
    // R1
    no_fill_without_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!cmd_load_i && !valid && !(slot_i && fifo_empty_i)) |=> (!valid && pending == $past(pending)));

    // R2
    second_half_sets_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!cmd_load_i && pending && slot_i && fifo_empty_i) |=> (valid && !pending));

    // R6
    write_mode_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (host_rd_i && code[0]) |-> (host_ready_o && host_data_o == 16'h0000));

    // R7
    stall_until_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (host_rd_i && !code[0] && !valid) |-> !host_ready_o);

    // R8
    consume_advance_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (host_rd_i && host_ready_o && !code[0] && !cmd_load_i)
        |=> (!valid && addr == $past(addr) + 16'($past(autoinc_i))));

    // R9
    load_clears_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_load_i |=> (!valid && !pending));

    // R10
    bad_code_never_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!cmd_load_i && code != 4'b0000 && code != 4'b0100 && code != 4'b1000 && code != 4'b1100)
        |=> !valid);
endmodule

bind rd_prefetch_unit pf_checker u_pf_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .slot_i       (slot_i),
    .fifo_empty_i (fifo_empty_i),
    .cmd_load_i   (cmd_load_i),
    .autoinc_i    (autoinc_i),
    .host_rd_i    (host_rd_i),
    .host_ready_o (host_ready_o),
    .host_data_o  (host_data_o),
    .valid        (valid_q),
    .pending      (pending_q),
    .code         (code_q),
    .addr         (addr_q)
);

// File: tb/rd_prefetch_unit_test.sv
module rd_prefetch_unit_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        slot_i = 1'b0;
    logic        fifo_empty_i = 1'b1;
    logic [15:0] fifo_last_i = 16'h0;
    logic        cmd_load_i = 1'b0;
    logic [3:0]  cmd_code_i = 4'h0;
    logic [15:0] cmd_addr_i = 16'h0;
    logic [7:0]  autoinc_i = 8'h0;
    logic        host_rd_i = 1'b0;
    logic        host_ready_o;
    logic [15:0] host_data_o;
    logic        mem_we_i = 1'b0;
    logic [1:0]  mem_sel_i = 2'd0;
    logic [15:0] mem_addr_i = 16'h0;
    logic [15:0] mem_wdata_i = 16'h0;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;

    logic [7:0]  vm [1024];
    logic [15:0] cm [64];
    logic [15:0] sm [40];

    always #5 clk = ~clk;

    rd_prefetch_unit uut (
        .clk(clk), .rst_n(rst_n), .slot_i(slot_i), .fifo_empty_i(fifo_empty_i),
        .fifo_last_i(fifo_last_i), .cmd_load_i(cmd_load_i), .cmd_code_i(cmd_code_i),
        .cmd_addr_i(cmd_addr_i), .autoinc_i(autoinc_i), .host_rd_i(host_rd_i),
        .host_ready_o(host_ready_o), .host_data_o(host_data_o), .mem_we_i(mem_we_i),
        .mem_sel_i(mem_sel_i), .mem_addr_i(mem_addr_i), .mem_wdata_i(mem_wdata_i)
    );

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 150000) begin
            fails = fails + 1;
            checks = checks + 1;
            $display("FAIL watchdog: run did not finish, actual %0d cycles expected below 150000", cyc);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [15:0] expv(input logic [3:0] c, input logic [15:0] a, input logic [15:0] fl);
        logic [5:0] vi;
        case (c)
            4'b0000: return {vm[{a[9:1], 1'b0}], vm[{a[9:1], 1'b1}]};
            4'b1100: return {fl[15:8], vm[{a[9:1], ~a[0]}]};
            4'b1000: return (cm[a[6:1]] & 16'h0EEE) | (fl & 16'hF111);
            4'b0100: begin
                vi = a[6:1];
                if (vi >= 6'd40) vi = 6'd0;
                return (sm[vi] & 16'h07FF) | (fl & 16'hF800);
            end
            default: return 16'h0;
        endcase
    endfunction

    task automatic mem_wr(input logic [1:0] sel, input logic [15:0] a, input logic [15:0] d);
        mem_we_i = 1'b1; mem_sel_i = sel; mem_addr_i = a; mem_wdata_i = d;
        @(negedge clk);
        mem_we_i = 1'b0;
    endtask

    task automatic load_cmd(input logic [3:0] c, input logic [15:0] a);
        slot_i = 1'b0;
        cmd_load_i = 1'b1; cmd_code_i = c; cmd_addr_i = a;
        @(negedge clk);
        cmd_load_i = 1'b0;
    endtask

    // host read with slots every cycle; checks data and stall length
    task automatic host_read(input logic [15:0] exp, input int exp_wait, input string req);
        int waited;
        host_rd_i = 1'b1; slot_i = 1'b1; fifo_empty_i = 1'b1;
        #1;
        waited = 0;
        while (!host_ready_o && waited < 60) begin
            @(negedge clk);
            waited++;
        end
        chk(host_data_o == exp && host_ready_o, req, {15'h0, host_ready_o, host_data_o}, {16'h1, exp});
        if (exp_wait >= 0)
            chk(waited == exp_wait, {req, " stall"}, 32'(waited), 32'(exp_wait));
        @(negedge clk);
        host_rd_i = 1'b0; slot_i = 1'b0;
    endtask

    function automatic int wait_of(input logic [3:0] c);
        return (c == 4'b0000) ? 2 : 1;
    endfunction

    task automatic hold_no_ready(input int n, input string req);
        bit seen;
        seen = 0;
        for (int i = 0; i < n; i++) begin
            #1;
            if (host_ready_o) seen = 1;
            @(negedge clk);
        end
        chk(!seen, req, 32'(seen), 32'h0);
    endtask

    initial begin
        logic [15:0] a;
        logic [3:0]  c;
        logic [3:0]  codes [4];
        int n;
        codes[0] = 4'b0000; codes[1] = 4'b0100; codes[2] = 4'b1000; codes[3] = 4'b1100;
        void'($urandom(32'd2718));

        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        // reset state: VRAM word code, nothing valid -> a read stalls (R7)
        host_rd_i = 1'b1;
        #1 chk(!host_ready_o, "R7 reset stall", 32'(host_ready_o), 32'h0);
        host_rd_i = 1'b0;

        for (int i = 0; i < 1024; i++) begin
            vm[i] = 8'($urandom);
            mem_wr(2'd0, 16'(i), {8'hA5, vm[i]});
        end
        for (int i = 0; i < 64; i++) begin
            cm[i] = 16'($urandom);
            mem_wr(2'd1, 16'(i), cm[i]);
        end
        for (int i = 0; i < 40; i++) begin
            sm[i] = 16'($urandom);
            mem_wr(2'd2, 16'(i), sm[i]);
        end

        // R2 word read takes two slots, odd start address
        fifo_last_i = 16'hBEEF;
        load_cmd(4'b0000, 16'h0123);
        host_read(expv(4'b0000, 16'h0123, fifo_last_i), 2, "R2 word read");

        // R3 byte read, merge high byte
        load_cmd(4'b1100, 16'h0200);
        host_read(expv(4'b1100, 16'h0200, fifo_last_i), 1, "R3 byte read even");
        load_cmd(4'b1100, 16'h0201);
        host_read(expv(4'b1100, 16'h0201, fifo_last_i), 1, "R3 byte read odd");

        // R4 colour RAM, index wraps
        fifo_last_i = 16'hFFFF;
        load_cmd(4'b1000, 16'h1082);
        host_read(expv(4'b1000, 16'h1082, fifo_last_i), 1, "R4 cram wrap");

        // R5 vertical scroll, in range and folded indices
        fifo_last_i = 16'h5A5A;
        load_cmd(4'b0100, 16'h004E);
        host_read(expv(4'b0100, 16'h004E, fifo_last_i), 1, "R5 vsram idx39");
        load_cmd(4'b0100, 16'h0060);
        host_read(expv(4'b0100, 16'h0060, fifo_last_i), 1, "R5 vsram idx48 folds");
        load_cmd(4'b0100, 16'hFFFE);
        host_read(expv(4'b0100, 16'hFFFE, fifo_last_i), 1, "R5 vsram idx63 folds");

        // R6 write mode answers immediately with zero
        load_cmd(4'b0001, 16'h0010);
        host_read(16'h0000, 0, "R6 write mode");

        // R1 queue not empty / no slot blocks fill
        load_cmd(4'b1000, 16'h0008);
        host_rd_i = 1'b1; slot_i = 1'b1; fifo_empty_i = 1'b0;
        hold_no_ready(5, "R1 queue busy");
        fifo_empty_i = 1'b1; slot_i = 1'b0;
        hold_no_ready(4, "R1 no slot");
        host_read(expv(4'b1000, 16'h0008, fifo_last_i), 1, "R1 fill after release");

        // R9 pending half-fetch discarded by reload
        load_cmd(4'b0000, 16'h0040);
        slot_i = 1'b1; @(negedge clk); slot_i = 1'b0;
        load_cmd(4'b0000, 16'h0300);
        host_read(expv(4'b0000, 16'h0300, fifo_last_i), 2, "R9 pending cleared");
        // R9 valid discarded by reload
        load_cmd(4'b0100, 16'h0002);
        slot_i = 1'b1; @(negedge clk); slot_i = 1'b0;
        load_cmd(4'b0100, 16'h0004);
        host_read(expv(4'b0100, 16'h0004, fifo_last_i), 1, "R9 valid cleared");

        // R10 unsupported read code stalls forever
        load_cmd(4'b0010, 16'h0000);
        host_rd_i = 1'b1; slot_i = 1'b1; fifo_empty_i = 1'b1;
        hold_no_ready(8, "R10 bad code");
        host_rd_i = 1'b0; slot_i = 1'b0;

        // R8 auto-increment sequences, including zero step and wrap
        autoinc_i = 8'd2;
        load_cmd(4'b0000, 16'h03FC);
        a = 16'h03FC;
        for (int k = 0; k < 4; k++) begin
            host_read(expv(4'b0000, a, fifo_last_i), 2, "R8 word step2");
            a = a + 16'd2;
        end
        autoinc_i = 8'd0;
        load_cmd(4'b1000, 16'h0006);
        host_read(expv(4'b1000, 16'h0006, fifo_last_i), 1, "R8 step0 first");
        host_read(expv(4'b1000, 16'h0006, fifo_last_i), 1, "R8 step0 repeat");
        autoinc_i = 8'h80;
        load_cmd(4'b1100, 16'hFFC1);
        host_read(expv(4'b1100, 16'hFFC1, fifo_last_i), 1, "R8 pre wrap");
        host_read(expv(4'b1100, 16'h0041, fifo_last_i), 1, "R8 address wrap");

        // random mix
        for (int it = 0; it < 60; it++) begin
            c = codes[$urandom_range(0, 3)];
            a = 16'($urandom);
            autoinc_i = 8'($urandom_range(0, 9));
            fifo_last_i = 16'($urandom);
            n = $urandom_range(1, 4);
            load_cmd(c, a);
            for (int k = 0; k < n; k++) begin
                host_read(expv(c, a, fifo_last_i), wait_of(c), "R8 random read");
                a = a + 16'(autoinc_i);
            end
        end

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule